// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointer Crossing

This block carries a stream of data words from one clock domain to another clock domain that is unrelated to it. A producer on the write clock offers a word together with a push strobe. A consumer on the read clock takes the word at the head of the queue with a pop strobe. Storage is a dual-ported memory. It is written on the write clock and read through its second port at the read pointer. The word at the head is therefore already on the read data output whenever the queue is not empty, and no extra cycle of latency follows the flag.

Each side is a self-contained synchronous machine that owns one pointer. The only signals that cross between the domains are the two pointers. Each pointer crosses in Gray code through a two-stage synchronizer in the receiving domain. Fullness and emptiness come only from comparing pointers, never from the other side's strobe. A synchronized pointer is always stale, so a flag may be raised too early or lowered too late, but it is never raised too late. Each side also has a registered "nearly" flag with a margin set by a parameter.

Top module: `dcf_fifo`

## Requirements
- R1: After reset, empty and almost_empty are 1 and full and almost_full are 0.
- R2: A push is taken at a write-clock edge only when full is 0. While the read side is idle and its pointer has settled, full becomes 1 right after the push that brings the stored word count to 2^ADDR_W.
- R3: A push made while full is 1 is discarded. Nothing is overwritten and the write pointer does not move.
- R4: Words leave in the order they arrived. While empty is 0, rdata shows the head word, and a pop at a read-clock edge moves on to the next word. empty becomes 1 right after the pop that removes the last word the read side knows of.
- R5: A pop made while empty is 1 is discarded, and the read pointer does not move.
- R6: almost_full is 1 exactly when the write side's count (its own pointer minus the synchronized read pointer) is at least 2^ADDR_W − AF_MARGIN. full implies almost_full.
- R7: almost_empty is 1 exactly when the read side's count (the synchronized write pointer minus its own pointer) is at most AE_MARGIN. empty implies almost_empty.
- R8: Each pointer that crosses domains is Gray-coded. Between two successive edges of its own clock it changes in at most one bit.
- R9: After a push into an empty FIFO, empty stays 1 on the same cycle. It falls no later than the third rising read-clock edge after the write edge, because of two synchronizer flops and one flag register.
- R10: With push and pop running at the same time under unrelated clocks and throttling, every word arrives exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst_n | input | 1 | Write-side asynchronous reset, active low |
| push | input | 1 | Write request |
| wdata | input | DATA_W | Word to be written |
| full | output | 1 | No free entry (write view) |
| almost_full | output | 1 | Write-side count at or above threshold |
| rclk | input | 1 | Read-side clock |
| rrst_n | input | 1 | Read-side asynchronous reset, active low |
| pop | input | 1 | Read request |
| rdata | output | DATA_W | Head word, valid while empty is 0 |
| empty | output | 1 | No stored word (read view) |
| almost_empty | output | 1 | Read-side count at or below threshold |

## Verification
A small instance with eight entries is filled one word at a time and then drained one word at a time. After every step both flags are compared with the exact count. This covers every fill level and separates an off-by-one threshold from a correct one. Extra pushes while full and extra pops while empty show whether a pointer leaks: a discarded push would appear as a stray word in the drain, and a discarded pop would hide the next word pushed. A single push into an empty FIFO measures the latency of the crossing. A long throttled run with both sides active at once, under clock periods that are not multiples of each other, looks for loss, duplication or reordering while the pointers cross as they wrap.

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/dcf_gray2bin.sv
module dcf_gray2bin #(
    parameter int W = 4
) (
    input  logic [W-1:0] gray,
    output logic [W-1:0] bin
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bin[i] = ^gray[W-1:i];
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
    parameter int ADDR_W    = 5,
    parameter int AF_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [ADDR_W:0]   rgray_async,
    output logic              wr_en,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              almost_full
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam logic [PW-1:0] AF_LEVEL = PW'(DEPTH - AF_MARGIN);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
    } wr_state_t;

    wr_state_t     st_d, st_q;
    logic [PW-1:0] rgray_s, rbin_s, level_d;
    logic          accept;

    dcf_sync #(.W(PW)) u_rsync (
        .clk(clk), .rst_n(rst_n), .async_in(rgray_async), .sync_out(rgray_s)
    );

    dcf_gray2bin #(.W(PW)) u_rconv (.gray(rgray_s), .bin(rbin_s));

    always_comb begin
        accept     = push && !st_q.full;
        st_d.bin   = st_q.bin + PW'(accept);
        st_d.gray  = st_d.bin ^ (st_d.bin >> 1);
        st_d.full  = (st_d.gray == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
        level_d    = st_d.bin - rbin_s;
        st_d.afull = (level_d >= AF_LEVEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_en       = accept;
    assign waddr       = st_q.bin[ADDR_W-1:0];
    assign wgray       = st_q.gray;
    assign full        = st_q.full;
    assign almost_full = st_q.afull;

    // R3: pushes into a full queue leave the pointer where it was
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push) |=> (st_q.bin == $past(st_q.bin)));
    // R8: the crossing pointer steps by one bit at most
    assert_wgray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
    // R6: full is a subset of almost_full
    assert_full_in_afull_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> almost_full);
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
    parameter int ADDR_W    = 5,
    parameter int AE_MARGIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic [ADDR_W:0]   wgray_async,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] AE_LEVEL = PW'(AE_MARGIN);

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          aempty;
    } rd_state_t;

    rd_state_t     st_d, st_q;
    logic [PW-1:0] wgray_s, wbin_s, level_d;
    logic          accept;

    dcf_sync #(.W(PW)) u_wsync (
        .clk(clk), .rst_n(rst_n), .async_in(wgray_async), .sync_out(wgray_s)
    );

    dcf_gray2bin #(.W(PW)) u_wconv (.gray(wgray_s), .bin(wbin_s));

    always_comb begin
        accept      = pop && !st_q.empty;
        st_d.bin    = st_q.bin + PW'(accept);
        st_d.gray   = st_d.bin ^ (st_d.bin >> 1);
        st_d.empty  = (st_d.gray == wgray_s);
        level_d     = wbin_s - st_d.bin;
        st_d.aempty = (level_d <= AE_LEVEL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};
        else        st_q <= st_d;
    end

    assign raddr        = st_q.bin[ADDR_W-1:0];
    assign rgray        = st_q.gray;
    assign empty        = st_q.empty;
    assign almost_empty = st_q.aempty;

    // R5: pops from an empty queue leave the pointer where it was
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop) |=> (st_q.bin == $past(st_q.bin)));
    // R8: the crossing pointer steps by one bit at most
    assert_rgray_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gray ^ $past(st_q.gray)) <= 1);
    // R7: empty is a subset of almost_empty
    assert_empty_in_aempty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> almost_empty);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 5,
    parameter int AF_MARGIN = 4,
    parameter int AE_MARGIN = 4
) (
    input  logic              wclk,
    input  logic              wrst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    output logic              almost_full,
    input  logic              rclk,
    input  logic              rrst_n,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    logic              wr_en;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray;

    dcf_wr_ctrl #(.ADDR_W(ADDR_W), .AF_MARGIN(AF_MARGIN)) u_wr (
        .clk(wclk), .rst_n(wrst_n), .push(push), .rgray_async(rgray),
        .wr_en(wr_en), .waddr(waddr), .wgray(wgray),
        .full(full), .almost_full(almost_full)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W), .AE_MARGIN(AE_MARGIN)) u_rd (
        .clk(rclk), .rst_n(rrst_n), .pop(pop), .wgray_async(wgray),
        .raddr(raddr), .rgray(rgray),
        .empty(empty), .almost_empty(almost_empty)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(wr_en), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: tb/tb_dcf_fifo.sv
`timescale 1ns/1ps
module tb_dcf_fifo;
    localparam int DW = 8, AW = 3, AFM = 2, AEM = 2;
    localparam int DEPTH = 1 << AW;
    localparam int NSTREAM = 300;

    logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
    logic push = 0, pop = 0;
    logic [DW-1:0] wdata = '0, rdata;
    logic full, almost_full, empty, almost_empty;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2   wclk = ~wclk;
    always #3.5 rclk = ~rclk;

    dcf_fifo #(.DATA_W(DW), .ADDR_W(AW), .AF_MARGIN(AFM), .AE_MARGIN(AEM)) dut (
        .wclk(wclk), .wrst_n(wrst_n), .push(push), .wdata(wdata),
        .full(full), .almost_full(almost_full),
        .rclk(rclk), .rrst_n(rrst_n), .pop(pop), .rdata(rdata),
        .empty(empty), .almost_empty(almost_empty)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push_one(input logic [DW-1:0] v);
        @(negedge wclk); push = 1; wdata = v;
        @(negedge wclk); push = 0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge wclk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge rclk);
        wrst_n = 1; rrst_n = 1;
        @(negedge wclk);
        // R1 reset state
        chk(empty == 1, "R1 empty", empty, 1);
        chk(almost_empty == 1, "R1 almost_empty", almost_empty, 1);
        chk(full == 0, "R1 full", full, 0);
        chk(almost_full == 0, "R1 almost_full", almost_full, 0);

        // R2/R6 fill sweep
        for (int k = 1; k <= DEPTH; k++) begin
            push_one(8'(8'h10 + k));
            chk(full == (k == DEPTH), "R2 full at fill level", full, int'(k == DEPTH));
            chk(almost_full == (k >= DEPTH - AFM), "R6 almost_full at fill level",
                almost_full, int'(k >= DEPTH - AFM));
        end
        // R3 pushes while full
        push_one(8'hEE);
        push_one(8'hEF);
        chk(full == 1, "R3 full held", full, 1);

        repeat (10) @(negedge rclk);
        chk(empty == 0, "R4 empty after fill", empty, 0);
        chk(almost_empty == 0, "R7 almost_empty at full", almost_empty, 0);

        // R4/R7 drain sweep; R3 no stray words
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge rclk);
            chk(rdata == 8'(8'h11 + k), "R4 head word", rdata, 8'h11 + k);
            pop = 1;
            @(negedge rclk); pop = 0;
            chk(empty == (k == DEPTH - 1), "R4/R3 empty at drain level",
                empty, int'(k == DEPTH - 1));
            chk(almost_empty == (DEPTH - 1 - k <= AEM), "R7 almost_empty at drain level",
                almost_empty, int'(DEPTH - 1 - k <= AEM));
        end

        // R5 pops while empty
        @(negedge rclk); pop = 1;
        repeat (2) @(negedge rclk);
        pop = 0;
        chk(empty == 1, "R5 empty held", empty, 1);
        repeat (10) @(negedge wclk);
        chk(full == 0, "R2 full after drain", full, 0);
        chk(almost_full == 0, "R6 almost_full after drain", almost_full, 0);

        // R9 latency, R5 pointer did not move
        push_one(8'h5A);
        @(negedge rclk);
        chk(empty == 1, "R9 empty still set", empty, 1);
        repeat (3) @(posedge rclk);
        @(negedge rclk);
        chk(empty == 0, "R9 empty cleared", empty, 0);
        chk(rdata == 8'h5A, "R5 head after ignored pops", rdata, 8'h5A);
        pop = 1;
        @(negedge rclk); pop = 0;
        chk(empty == 1, "R4 empty after single", empty, 1);

        // R10 concurrent streaming
        fork
            begin : writer
                int i = 0;
                int cyc = 0;
                while (i < NSTREAM) begin
                    @(negedge wclk);
                    push = 0;
                    if (!full && (cyc % 7) < 5) begin
                        push = 1; wdata = 8'(i); i++;
                    end
                    cyc++;
                end
                @(negedge wclk); push = 0;
            end
            begin : reader
                int e = 0;
                int cyc = 0;
                while (e < NSTREAM) begin
                    @(negedge rclk);
                    pop = 0;
                    if (!empty && (cyc % 4) != 1) begin
                        chk(rdata == 8'(e), "R10 stream order", rdata, e % 256);
                        pop = 1; e++;
                    end
                    cyc++;
                end
                @(negedge rclk); pop = 0;
            end
        join
        repeat (10) @(negedge rclk);
        chk(empty == 1, "R10 empty after stream", empty, 1);
        done = 1;
        finish_run();
    end
endmodule